// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word from a 64-word serial EEPROM that speaks the three-wire select/clock/data protocol. A host presents a 6-bit word address with a one-cycle start strobe. The block then raises chip select and clocks out a fixed read command and the address. It clocks in the 16 data bits, drops chip select, and returns the word with a one-cycle done pulse.

The serial clock comes from a half-period counter of `HALF_CYC` system clocks. The default of 500 gives 5 µs per half-period at 100 MHz. Every phase of the transaction lasts exactly one half-period, and that includes the low half before the first rising edge and the low half after the last falling edge. The block is read-only. It has no write, erase or enable commands.

Top module: `sprom_word_reader`

## Requirements
- R1: `cs_o` rises before the first rising edge of `sk_o`. It stays high through all 25 clock pulses and falls only in the cycle in which `done_o` is high. `sk_o` is never high while `cs_o` is low.
- R2: The first three `sk_o` pulses of a transaction carry the read opcode on `ser_out_o`, in the order 1, 1, 0.
- R3: The next six pulses carry the word address latched at the start strobe, most significant bit first. Changes on `addr_i` after the start strobe have no effect.
- R4: `ser_out_o` changes only while `sk_o` is low. It holds its value for the whole high half-period.
- R5: Every high and low phase of `sk_o` lasts exactly `HALF_CYC` system clocks, and so do the lead phase (from the rise of `cs_o` to the first rise of `sk_o`) and the tail phase (from the last fall of `sk_o` to the fall of `cs_o`).
- R6: Exactly 16 more pulses follow the address, for 25 pulses in all. `ser_in_i` is sampled in the last system cycle of each high phase and shifted in MSB first, so `data_o` equals the word the memory drove.
- R7: `done_o` is a single-cycle pulse that comes exactly 51·`HALF_CYC` system clocks after the clock edge that accepts the start strobe. `busy_o` is high from the cycle after that edge and goes low in the `done_o` cycle.
- R8: A start strobe that arrives while `busy_o` is high is ignored. The address sent, the pulse count, the latency and the returned word all stay those of the running transaction.
- R9: `data_o` is 0 after reset and changes only in a cycle in which `done_o` is high. Between done pulses it holds its value.
- R10: During reset, `cs_o`, `sk_o`, `ser_out_o`, `busy_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | ADDR_W (6) | Word address, sampled with the accepted start |
| busy_o | output | 1 | A transaction is in progress |
| done_o | output | 1 | One-cycle pulse: `data_o` holds the new word |
| data_o | output | DATA_W (16) | Last word read |
| cs_o | output | 1 | Memory chip select, active high |
| sk_o | output | 1 | Serial clock to the memory |
| ser_out_o | output | 1 | Serial command/address to the memory |
| ser_in_i | input | 1 | Serial data from the memory |

## Verification
A behavioural memory model in the bench returns words from a seeded random table. Directed words are placed at the address extremes, and the extremes read all-ones and all-zeros data (0xFFFF at address 0, 0x0000 at address 63), so a stuck data line or a mis-shifted address shows up as a wrong word. Random addresses in sequence, some issued back to back, check that each transaction re-latches its own address and restarts framing cleanly. A second strobe injected mid-transaction, with a different address on the bus, tells a block that ignores it apart from one that restarts or re-latches. Edge-to-edge timing measured on `sk_o` and `cs_o` separates equal half-periods from lead or tail phases that are off by a cycle.

// File: rtl/sprom_pkg.sv
`timescale 1ns/1ps
package sprom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_state_e;

  localparam int unsigned RD_OP_W = 3;
  localparam logic [RD_OP_W-1:0] RD_OPCODE = 3'b110;
endpackage

// File: rtl/sprom_half_div.sv
`timescale 1ns/1ps
module sprom_half_div #(
  parameter int unsigned HALF_CYC = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sprom_ctrl.sv
`timescale 1ns/1ps
module sprom_ctrl
  import sprom_pkg::*;
#(
  parameter int unsigned CMD_W  = 9,
  parameter int unsigned PULSES = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tick_i,
  output seq_state_e state_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       load_o,
  output logic       shift_o,
  output logic       cap_o,
  output logic       fin_o
);
  localparam int unsigned CNT_W = $clog2(PULSES);
  localparam logic [CNT_W-1:0] LAST_P  = CNT_W'(PULSES - 1);
  localparam logic [CNT_W-1:0] CMD_LIM = CNT_W'(CMD_W);

  seq_state_e state_q;
  logic [CNT_W-1:0] pcnt_q;
  logic done_q;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o = (state_q == ST_HIGH) && tick_i;
  assign cap_o   = shift_o && (pcnt_q >= CMD_LIM);
  assign fin_o   = (state_q == ST_TAIL) && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOW;
          pcnt_q  <= '0;
        end
        ST_LOW:  if (tick_i) state_q <= ST_HIGH;
        ST_HIGH: if (tick_i) begin
          if (pcnt_q == LAST_P) state_q <= ST_TAIL;
          else begin
            state_q <= ST_LOW;
            pcnt_q  <= pcnt_q + 1'b1;
          end
        end
        ST_TAIL: if (tick_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fin_o;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/sprom_shift.sv
`timescale 1ns/1ps
module sprom_shift #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 3,
  parameter logic [OP_W-1:0] OPCODE = 3'b110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              fin_i,
  input  logic              ser_in_i,
  output logic              ser_bit_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned CMD_W = OP_W + ADDR_W;

  logic [CMD_W-1:0]  tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] word_q;

  // command register empties to zero, so data phase drives low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_q <= '0;
    else if (load_i)  tx_q <= {OPCODE, addr_i};
    else if (shift_i) tx_q <= {tx_q[CMD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rx_q <= '0;
    else if (cap_i) rx_q <= {rx_q[DATA_W-2:0], ser_in_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (fin_i) word_q <= rx_q;
  end

  assign ser_bit_o = tx_q[CMD_W-1];
  assign word_o    = word_q;
endmodule

// File: rtl/sprom_word_reader.sv
`timescale 1ns/1ps
module sprom_word_reader
  import sprom_pkg::*;
#(
  parameter int unsigned HALF_CYC = 500,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              ser_out_o,
  input  logic              ser_in_i
);
  localparam int unsigned CMD_W  = RD_OP_W + ADDR_W;
  localparam int unsigned PULSES = CMD_W + DATA_W;

  seq_state_e state;
  logic tick, busy, load, shift, cap, fin, ser_bit;

  sprom_half_div #(.HALF_CYC(HALF_CYC)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .tick_o(tick)
  );

  sprom_ctrl #(.CMD_W(CMD_W), .PULSES(PULSES)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tick_i (tick),
    .state_o(state),
    .busy_o (busy),
    .done_o (done_o),
    .load_o (load),
    .shift_o(shift),
    .cap_o  (cap),
    .fin_o  (fin)
  );

  sprom_shift #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OP_W  (RD_OP_W),
    .OPCODE(RD_OPCODE)
  ) shift_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .addr_i   (addr_i),
    .shift_i  (shift),
    .cap_i    (cap),
    .fin_i    (fin),
    .ser_in_i (ser_in_i),
    .ser_bit_o(ser_bit),
    .word_o   (data_o)
  );

  assign busy_o    = busy;
  assign cs_o      = busy;
  assign sk_o      = (state == ST_HIGH);
  assign ser_out_o = ser_bit;
endmodule

// File: rtl/sprom_word_reader_chk.sv
`timescale 1ns/1ps
module sprom_word_reader_chk #(
  parameter int unsigned HALF_CYC = 500,
  parameter int unsigned DATA_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] data_o,
  input logic              cs_o,
  input logic              sk_o,
  input logic              ser_out_o
);
  logic        sk_q, cs_q;
  logic [31:0] run_q;

  // length of current (cs, sk) level in system cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q  <= 1'b0;
      cs_q  <= 1'b0;
      run_q <= '0;
    end else begin
      sk_q  <= sk_o;
      cs_q  <= cs_o;
      run_q <= (sk_o != sk_q || cs_o != cs_q) ? 32'd1 : run_q + 32'd1;
      if (cs_o && cs_q && sk_o != sk_q)
        AST_HALF_PERIOD: assert (run_q == 32'(HALF_CYC)) else $error("half period %0d", run_q); // R5
    end
  end

  AST_SK_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o); // R1
  AST_CS_DROP_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o); // R1
  AST_DOUT_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(ser_out_o)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> done_o); // R9
endmodule

bind sprom_word_reader sprom_word_reader_chk #(
  .HALF_CYC(HALF_CYC),
  .DATA_W  (DATA_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .data_o   (data_o),
  .cs_o     (cs_o),
  .sk_o     (sk_o),
  .ser_out_o(ser_out_o)
);

// File: tb/sprom_word_reader_tb_top.sv
`timescale 1ns/1ps
module sprom_word_reader_tb_top;
  localparam int H      = 4;
  localparam int PULSES = 25;
  localparam int LAT    = (2 * PULSES + 1) * H + 1;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, ser_in = 1'b0;
  logic [5:0]  addr = '0;
  logic        busy, done, cs, sk, ser_out;
  logic [15:0] data;

  always #5 clk = ~clk;

  sprom_word_reader #(.HALF_CYC(H), .ADDR_W(6), .DATA_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .data_o(data),
    .cs_o(cs), .sk_o(sk), .ser_out_o(ser_out), .ser_in_i(ser_in)
  );

  int checks = 0, errs = 0;
  logic [15:0] mem [64];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: records command, drives data on rising sk
  int bitn = 0;
  logic [5:0] exp_addr = '0, got_addr = '0;
  longint last_t = 0;
  logic sk_p = 1'b0, cs_p = 1'b0;

  always @(sk or cs) begin
    if (rst_ni) begin
      if (sk && !sk_p) chk(cs, "R1 clock pulse outside select", longint'(cs), 1);
      if (cs && !cs_p) begin
        bitn = 0; got_addr = '0; last_t = $time;
      end else if (cs && sk && !sk_p) begin
        chk(($time - last_t) == H * 10, "R5 low phase length", $time - last_t, H * 10);
        last_t = $time;
        bitn++;
        if (bitn <= 3)
          chk(ser_out == (bitn != 3), "R2 opcode bit", longint'(ser_out), longint'(bitn != 3));
        else if (bitn <= 9) begin
          got_addr = {got_addr[4:0], ser_out};
          chk(ser_out == exp_addr[9 - bitn], "R3 R4 address bit", longint'(ser_out),
              longint'(exp_addr[9 - bitn]));
        end else if (bitn <= PULSES)
          ser_in = mem[got_addr][PULSES - bitn];
      end else if (cs && !sk && sk_p) begin
        chk(($time - last_t) == H * 10, "R5 high phase length", $time - last_t, H * 10);
        last_t = $time;
      end else if (!cs && cs_p) begin
        chk(($time - last_t) == H * 10, "R5 tail length", $time - last_t, H * 10);
        chk(bitn == PULSES, "R6 pulse count", bitn, PULSES);
        chk(got_addr == exp_addr, "R3 R8 address sent", got_addr, exp_addr);
        ser_in = 1'b0;
      end
    end
    sk_p = sk;
    cs_p = cs;
  end

  function automatic logic [15:0] exp_word(input logic [5:0] a);
    return mem[a];
  endfunction

  task automatic do_read(input logic [5:0] a, input bit inject);
    int n;
    logic [15:0] prev;
    @(negedge clk);
    start = 1'b1; addr = a; exp_addr = a; prev = data;
    @(negedge clk);
    start = 1'b0; addr = 6'($urandom);
    n = 1;
    chk(busy, "R7 busy after start", longint'(busy), 1);
    while (!done && n < LAT + 20) begin
      if (inject && n == 20) begin start = 1'b1; addr = a ^ 6'h15; end
      else start = 1'b0;
      if (n == 30) chk(data == prev, "R9 hold while busy", data, prev);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == LAT, inject ? "R8 R7 latency with extra start" : "R7 latency", n, LAT);
    chk(data == exp_word(a), inject ? "R8 word after extra start" : "R6 word", data, exp_word(a));
    chk(!busy, "R7 busy low at done", longint'(busy), 0);
    @(negedge clk);
    chk(!done, "R7 done single cycle", longint'(done), 0);
    chk(data == exp_word(a), "R9 word held", data, exp_word(a));
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0]  = 16'hFFFF;
    mem[63] = 16'h0000;
    mem[21] = 16'hA5A5;
    mem[42] = 16'h8001;

    repeat (3) @(negedge clk);
    chk(!cs && !sk && !ser_out, "R10 serial pins in reset", {cs, sk, ser_out}, 0);
    chk(!busy && !done, "R10 busy/done in reset", {busy, done}, 0);
    chk(data == 16'h0, "R9 reset word", data, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    do_read(6'd0, 1'b0);
    do_read(6'd63, 1'b0);
    do_read(6'd21, 1'b0);
    repeat (10) @(negedge clk);
    chk(data == mem[21], "R9 idle hold", data, mem[21]);
    do_read(6'd42, 1'b1);
    for (int k = 0; k < 20; k++) begin
      do_read(6'($urandom), 1'b0);
      if (k % 3 == 0) repeat (int'($urandom_range(0, 7))) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule